// File: doc/BRIEF.md
# Multi-configuration cache hit profiler

This block watches the address stream a processor sends to memory and, in one pass over that stream, counts how many hits each of a whole family of candidate caches would have scored. The candidates vary in line size (1, 2 or 4 words of 8 bytes), number of sets (1, 2, 4 or 8) and associativity (1, 2 or 4 ways), which gives 36 configurations. Line size comes from a parameter set and the other two axes are evaluated for each line size.

For each line size the block keeps a most-recently-used stack of line addresses. Every stored entry is compared with the incoming line at the same time. The entries above the matching one are the lines touched since the last use of this line. For each set count, the block counts those entries that share the incoming line's set index. The access would hit in an A-way cache of that set count when the count is below A. After the search, the touched line moves to the top of the stack.

The block never stalls the source and accepts one address on every cycle that valid is high. A separate read port returns the hit count of one selected configuration together with the total access count, so that software or a controller can compute misses as accesses minus hits.

Top module: `mcache_eval`

## Requirements
- R1: After reset or a synchronous `clear_i`, all hit counters and the access counter read zero and every stack is empty. `clear_i` takes priority over `valid_i` in the same cycle.
- R2: For line size 2^k words (k = 0, 1, 2), the line address is the byte address shifted right by 3+k.
- R3: An access to the same line as the previous access counts as a hit in every configuration of that line size.
- R4: With one set, an access hits in an A-way configuration exactly when the number of distinct lines referenced since the last access to its line is less than A.
- R5: With 2^s sets (s > 0), the set index is the low s bits of the line address. Only entries above the match that have the same set index are counted, and the access hits in an A-way configuration when that count is less than A.
- R6: Each stack holds 16 lines. When a new line arrives at a full stack, the oldest entry is dropped, and a later reference to a dropped line misses in every configuration.
- R7: The access counter advances by one on each cycle that `valid_i` is high. Cycles with `valid_i` low leave all counters and stacks unchanged.
- R8: Every counter saturates at its all-ones value and does not wrap.
- R9: The configuration index is `ls*12 + s*3 + w`, where ls is log2 of the words per line, s is log2 of the sets and w is log2 of the ways. `hit_o` and `access_o` show the selected counts one cycle after `cfg_i` is presented. An index of 36 or more returns zero hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of counters and stacks |
| valid_i | input | 1 | Address on `addr_i` is a memory access |
| addr_i | input | ADDR_W | Byte address of the access |
| cfg_i | input | 6 | Configuration index to read |
| hit_o | output | CNT_W | Hit count of the selected configuration |
| access_o | output | CNT_W | Total number of accesses |

## Verification
The case hardest to reach from the ports is a reference to a line that is still deep in the stack, where the result for each set count depends on how many entries above it fall into the same set. The bench fills the one-word stack with 16 consecutive lines and then revisits line 1. The conflict count is then 14 with one set, 7 with two sets, 3 with four sets and 1 with eight sets, so every way threshold gives a different result. A second stream of 17 lines forces the stack to drop its oldest entry before that entry is revisited.

// File: rtl/mcache_eval_pkg.sv
package mcache_eval_pkg;
  localparam int unsigned NUM_LS     = 3;  // line sizes 1, 2, 4 words
  localparam int unsigned NUM_SL     = 4;  // sets 1, 2, 4, 8
  localparam int unsigned NUM_WL     = 3;  // ways 1, 2, 4
  localparam int unsigned WORD_SHIFT = 3;  // 8-byte words
  localparam int unsigned CFG_PER_LS = NUM_SL * NUM_WL;
  localparam int unsigned NUM_CFG    = NUM_LS * CFG_PER_LS;
  localparam int unsigned CFG_W      = 6;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clear_i)                  cnt_o <= '0;
    else if (inc_i && (cnt_o != '1))   cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/lru_probe.sv
module lru_probe #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SHIFT  = 3,
  parameter int unsigned NUM_SL = 4,
  localparam int unsigned LINE_W = ADDR_W - SHIFT,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         valid_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         found_o,
  output logic [NUM_SL-1:0][CW-1:0]    conf_o
);
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line;
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  above;   // entry is more recent than the match
  logic [DEPTH-1:0]  shift_en;

  assign line = addr_i[ADDR_W-1:SHIFT];

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      match[j] = vld_q[j] && (line_q[j] == line);
      above[j] = seen;
      seen     = seen | match[j];
    end
    found_o = seen;
  end

  for (genvar s = 0; s < NUM_SL; s++) begin : g_set
    localparam logic [LINE_W-1:0] MASK = LINE_W'((1 << s) - 1);
    always_comb begin
      conf_o[s] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (above[j] && vld_q[j] && (((line_q[j] ^ line) & MASK) == '0))
          conf_o[s] = conf_o[s] + CW'(1);
    end
  end

  always_comb begin
    shift_en[0] = 1'b1;
    for (int j = 1; j < DEPTH; j++)
      shift_en[j] = !found_o || above[j-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int j = 0; j < DEPTH; j++) line_q[j] <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (valid_i) begin
      vld_q[0]  <= 1'b1;
      line_q[0] <= line;
      for (int j = 1; j < DEPTH; j++)
        if (shift_en[j]) begin
          vld_q[j]  <= vld_q[j-1];
          line_q[j] <= line_q[j-1];
        end
    end
  end
endmodule

// File: rtl/hit_bank.sv
module hit_bank #(
  parameter int unsigned NUM_SL = 4,
  parameter int unsigned NUM_WL = 3,
  parameter int unsigned CW     = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                clear_i,
  input  logic                                valid_i,
  input  logic                                found_i,
  input  logic [NUM_SL-1:0][CW-1:0]           conf_i,
  output logic [NUM_SL*NUM_WL-1:0][CNT_W-1:0] cnt_o
);
  for (genvar s = 0; s < NUM_SL; s++) begin : g_s
    for (genvar w = 0; w < NUM_WL; w++) begin : g_w
      localparam logic [CW-1:0] WAYS = CW'(1 << w);
      logic hit;
      assign hit = valid_i && found_i && (conf_i[s] < WAYS);
      sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(clear_i),
        .inc_i  (hit),
        .cnt_o  (cnt_o[s*NUM_WL+w])
      );
    end
  end
endmodule

// File: rtl/mcache_eval.sv
module mcache_eval
  import mcache_eval_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [CNT_W-1:0]  hit_o,
  output logic [CNT_W-1:0]  access_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [NUM_CFG-1:0][CNT_W-1:0] all_cnt;
  logic [CNT_W-1:0]              acc_cnt;
  logic [CNT_W-1:0]              sel_cnt;
  logic                          acc_inc;

  assign acc_inc = valid_i;

  for (genvar k = 0; k < NUM_LS; k++) begin : g_ls
    logic                      found;
    logic [NUM_SL-1:0][CW-1:0] conf;
    logic [CFG_PER_LS-1:0][CNT_W-1:0] bank;

    lru_probe #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH),
      .SHIFT (WORD_SHIFT + k), .NUM_SL(NUM_SL)
    ) u_probe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .valid_i(valid_i),
      .addr_i (addr_i),
      .found_o(found),
      .conf_o (conf)
    );

    hit_bank #(
      .NUM_SL(NUM_SL), .NUM_WL(NUM_WL), .CW(CW), .CNT_W(CNT_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .valid_i(valid_i),
      .found_i(found),
      .conf_i (conf),
      .cnt_o  (bank)
    );

    for (genvar c = 0; c < CFG_PER_LS; c++) begin : g_map
      assign all_cnt[k*CFG_PER_LS+c] = bank[c];
    end
  end

  sat_counter #(.CNT_W(CNT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .inc_i  (acc_inc),
    .cnt_o  (acc_cnt)
  );

  always_comb begin
    sel_cnt = '0;
    for (int c = 0; c < NUM_CFG; c++)
      if (cfg_i == CFG_W'(c)) sel_cnt = all_cnt[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= '0;
      access_o <= '0;
    end else begin
      hit_o    <= sel_cnt;
      access_o <= acc_cnt;
    end
  end
endmodule

// File: rtl/mcache_eval_chk.sv
module mcache_eval_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             valid_i,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [CNT_W-1:0] hit_o,
  input logic [CNT_W-1:0] access_o
);
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_cnt == '0)); // R1

  AST_ACCESS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && (acc_cnt != '1)) |=> (acc_cnt == $past(acc_cnt) + CNT_W'(1))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(acc_cnt)); // R7

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (acc_cnt == '1)) |=> (acc_cnt == '1)); // R8

  AST_HIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o <= access_o); // R9
endmodule

bind mcache_eval mcache_eval_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .valid_i (valid_i),
  .acc_cnt (acc_cnt),
  .hit_o   (hit_o),
  .access_o(access_o)
);

// File: tb/mcache_eval_test.sv
module mcache_eval_test;
  localparam int unsigned CNT_W = 8;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clear_i = 1'b0;
  logic             valid_i = 1'b0;
  logic [31:0]      addr_i = '0;
  logic [5:0]       cfg_i = '0;
  logic [CNT_W-1:0] hit_o, access_o;
  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mcache_eval #(.ADDR_W(32), .DEPTH(16), .CNT_W(CNT_W)) uut (
    .clk_i, .rst_ni, .clear_i, .valid_i, .addr_i, .cfg_i, .hit_o, .access_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk_i); valid_i = 1'b1; addr_i = a;
  endtask

  task automatic idle();
    @(negedge clk_i); valid_i = 1'b0; addr_i = 32'hdead_beef;
  endtask

  task automatic do_clear();
    @(negedge clk_i); clear_i = 1'b1; valid_i = 1'b0;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic read_cfg(input int ls, input int s, input int w,
                          input int exp, input string req);
    @(negedge clk_i); cfg_i = 6'(ls*12 + s*3 + w);
    @(negedge clk_i);
    chk(req, int'(hit_o), exp);
  endtask

  task automatic read_acc(input int exp, input string req);
    @(negedge clk_i);
    chk(req, int'(access_o), exp);
  endtask

  task automatic t_reset();
    read_acc(0, "R1 reset access");
    read_cfg(2, 3, 2, 0, "R1 reset hits");
  endtask

  task automatic t_repeat();
    do_clear();
    for (int i = 0; i < 4; i++) send(32'h100);
    idle();
    read_acc(4, "R7 access count");
    read_cfg(0, 0, 0, 3, "R3 repeat 1w/1s/1w");
    read_cfg(1, 2, 1, 3, "R3 repeat 2w/4s/2w");
    read_cfg(2, 3, 2, 3, "R3 repeat 4w/8s/4w");
  endtask

  task automatic t_sequence();
    do_clear();
    for (int i = 0; i < 4; i++) send(32'(8*i));
    send(32'h0);
    idle();
    read_cfg(0, 0, 1, 0, "R4 1w fa 2-way");
    read_cfg(0, 0, 2, 1, "R4 1w fa 4-way");
    read_cfg(0, 1, 0, 0, "R5 1w 2s 1-way");
    read_cfg(0, 1, 1, 1, "R5 1w 2s 2-way");
    read_cfg(0, 2, 0, 1, "R5 1w 4s 1-way");
    read_cfg(1, 0, 0, 2, "R2 2w fa 1-way");
    read_cfg(1, 1, 0, 3, "R2 2w 2s 1-way");
    read_cfg(2, 0, 0, 4, "R2 4w fa 1-way");
    // R9 latency: value holds until the edge after the index changes
    @(negedge clk_i); cfg_i = 6'(0*12 + 0*3 + 2);
    #1 chk("R9 before edge", int'(hit_o), 4);
    @(negedge clk_i);
    chk("R9 after edge", int'(hit_o), 1);
    @(negedge clk_i); cfg_i = 6'd40;
    @(negedge clk_i);
    chk("R9 out of range", int'(hit_o), 0);
  endtask

  task automatic t_deep();
    do_clear();
    for (int i = 0; i < 16; i++) send(32'(8*i));
    send(32'h8);
    idle();
    read_cfg(0, 0, 2, 0, "R4 deep fa 4-way");
    read_cfg(0, 1, 2, 0, "R5 deep 2s 4-way");
    read_cfg(0, 2, 1, 0, "R5 deep 4s 2-way");
    read_cfg(0, 2, 2, 1, "R5 deep 4s 4-way");
    read_cfg(0, 3, 0, 0, "R5 deep 8s 1-way");
    read_cfg(0, 3, 1, 1, "R5 deep 8s 2-way");
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < 17; i++) send(32'(8*i));
    send(32'h0);
    idle();
    read_cfg(0, 3, 2, 0, "R6 dropped line 8s 4-way");
    read_cfg(0, 0, 2, 0, "R6 dropped line fa 4-way");
    read_acc(18, "R6 access count");
  endtask

  task automatic t_idle_ignored();
    do_clear();
    send(32'h40); send(32'h40);
    idle();
    for (int i = 1; i < 6; i++) begin
      @(negedge clk_i); addr_i = 32'(i * 32'h1000);
    end
    read_acc(2, "R7 idle leaves access");
    send(32'h40);
    idle();
    read_cfg(0, 0, 0, 2, "R7 idle leaves stack");
  endtask

  task automatic t_clear_priority();
    send(32'h40);
    @(negedge clk_i); clear_i = 1'b1; valid_i = 1'b1; addr_i = 32'h40;
    @(negedge clk_i); clear_i = 1'b0; valid_i = 1'b0;
    read_acc(0, "R1 clear beats valid");
    send(32'h40);
    idle();
    read_cfg(0, 0, 2, 0, "R1 stack emptied");
  endtask

  task automatic t_saturate();
    do_clear();
    for (int i = 0; i < 300; i++) send(32'h80);
    idle();
    read_acc(255, "R8 access saturates");
    read_cfg(1, 1, 1, 255, "R8 hits saturate");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_repeat();
    t_sequence();
    t_deep();
    t_overflow();
    t_idle_ignored();
    t_clear_priority();
    t_saturate();
    finish_run();
  end
endmodule